// File: doc/BRIEF.md
# Microsecond Limit-Wrap Interval Timer

This block is a periodic interval timer on a plain 32-bit register bus. A tick-enable input gives the count rate, normally one pulse per microsecond. On each accepted tick an upward counter advances. Once the next value would reach the programmed limit, the counter reloads to 1 instead of 0. The counter therefore shows the values 1 to limit-1, and software that wants a period of N ticks writes N+1. The block applies no correction of its own. Each reload sets a sticky limit-reached flag, and that flag drives a level interrupt. Software clears the flag by reading the limit register.

Two limit addresses exist. The resetting one also restarts the count at 1 and clears the flag. The non-resetting alias changes only the limit, so software can retune the period while the count keeps running. A configuration bit puts the counter in user mode. In that mode a separate run bit gates the ticks. The position and width of the count field are parameters. The default map holds 21 bits at bit 10. The alternative map holds 22 bits at bit 9, with half-microsecond steps. A chip that needs two interrupt priority levels places two instances.

Top module: `lwt_timer`

## Requirements
- R1: After a synchronous reset the count is 1, the limit is 0, the flag is 0, irq is 0, and the run and user bits are 0.
- R2: On each tick taken, let nxt be count+1. If nxt is below the effective limit, the count becomes nxt. Otherwise the count reloads to 1 and the flag is set. With limit L >= 2, counting from 1 gives a period of L-1 ticks (L=4 gives 1,2,3,1,...). With no tick taken, the count holds.
- R3: A limit field of 0 means full range. The count runs up to the all-ones field value, reloads to 1 on the next tick and sets the flag.
- R4: Word offsets are 0 = limit, 1 = count, 2 = non-resetting limit alias, 3 = run, 4 = config. In limit and count words, bit 31 reads the flag and the field sits at bits FIELD_LSB+FIELD_W-1..FIELD_LSB. All other bits read 0. Writes to offset 1 are ignored.
- R5: A write to offset 0 loads the limit from the written field, reloads the count to 1 and clears the flag, all in one cycle. A tick in the same cycle is ignored.
- R6: A write to offset 2 loads the limit but leaves the count and the flag as they are.
- R7: irq equals the flag. A read of offset 0 clears the flag on that clock edge, unless a reload sets it on the same edge. A read of offset 2 or 1 leaves the flag as it is.
- R8: Config bit 0 = 1 selects user mode. In user mode a tick is taken only while run bit 0 = 1. While the run bit is 0 the count holds and reads still return the live value. With config bit 0 = 0 every tick is taken, whatever the run bit holds. The run and config words read back only bit 0.
- R9: FIELD_W and FIELD_LSB place the field. The alternative map (22 bits, least significant bit at 9) places count value v at v<<9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-rate enable, one pulse per step |
| bus_sel | input | 1 | Selects this instance for the current bus cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the flag-clearing read) |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
Read data is combinational. The bench presents the offset at a falling edge and samples bus_rdata shortly after, with no clock edge in between. Every register update, whether from a tick, a write or a flag-clearing read, lands on the next rising edge. Its effect is therefore sampled at the falling edge one cycle after the stimulus was driven, never earlier. irq comes straight from the flag register, so it follows the same one-edge rule. The bench checks irq at the first falling edge after the tick or read that should move it.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    localparam int WORD_W     = 32;
    localparam int FLAG_BIT   = 31;
    localparam int COARSE_W   = 21;
    localparam int COARSE_LSB = 10;
    localparam int FINE_W     = 22;
    localparam int FINE_LSB   = 9;

    typedef enum logic [2:0] {
        OFS_LIMIT    = 3'd0,
        OFS_COUNT    = 3'd1,
        OFS_LIMIT_NR = 3'd2,
        OFS_RUN      = 3'd3,
        OFS_CFG      = 3'd4
    } lwt_ofs_e;

    typedef struct packed {
        logic wr_limit;
        logic wr_alias;
        logic rd_limit;
        logic wr_run;
        logic wr_cfg;
    } lwt_strobe_t;

endpackage

// File: rtl/lwt_bus_decode.sv
module lwt_bus_decode
    import lwt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output lwt_strobe_t       strb
);

    logic wr_go;
    logic rd_go;

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & bus_rd;

    always_comb begin
        strb          = '0;
        strb.wr_limit = wr_go && (bus_addr == ADDR_W'(OFS_LIMIT));
        strb.wr_alias = wr_go && (bus_addr == ADDR_W'(OFS_LIMIT_NR));
        strb.wr_run   = wr_go && (bus_addr == ADDR_W'(OFS_RUN));
        strb.wr_cfg   = wr_go && (bus_addr == ADDR_W'(OFS_CFG));
        strb.rd_limit = rd_go && (bus_addr == ADDR_W'(OFS_LIMIT));
    end

endmodule

// File: rtl/lwt_ctrl.sv
module lwt_ctrl
    import lwt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  lwt_strobe_t strb,
    input  logic        wbit,
    output logic        run_q,
    output logic        user_q,
    output logic        advance
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            user_q <= 1'b0;
        end else begin
            if (strb.wr_run) run_q  <= wbit;
            if (strb.wr_cfg) user_q <= wbit;
        end
    end

    assign advance = tick & (~user_q | run_q);

endmodule

// File: rtl/lwt_counter.sv
module lwt_counter #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         wr_limit,
    input  logic         wr_alias,
    input  logic         rd_limit,
    input  logic [W-1:0] new_limit,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] lim_q,
    output logic         flag_q
);

    localparam logic [W:0] FULL_RANGE = {1'b1, {W{1'b0}}};

    logic [W:0] nxt;
    logic [W:0] lim_eff;
    logic       hit;

    assign nxt     = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign lim_eff = (lim_q == '0) ? FULL_RANGE : {1'b0, lim_q};
    assign hit     = (nxt >= lim_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= W'(1);
            lim_q  <= '0;
            flag_q <= 1'b0;
        end else if (wr_limit) begin
            lim_q  <= new_limit;
            cnt_q  <= W'(1);
            flag_q <= 1'b0;
        end else begin
            if (wr_alias) lim_q <= new_limit;
            if (advance) cnt_q <= hit ? W'(1) : nxt[W-1:0];
            if (advance && hit) flag_q <= 1'b1;
            else if (rd_limit)  flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lwt_timer.sv
module lwt_timer
    import lwt_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int FIELD_W   = COARSE_W,
    parameter int FIELD_LSB = COARSE_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    lwt_strobe_t        strb;
    logic               run_q;
    logic               user_q;
    logic               advance;
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] lim_q;
    logic               flag_q;
    logic [FIELD_W-1:0] wfield;
    logic               unused_wbits;

    assign wfield       = bus_wdata[FIELD_LSB +: FIELD_W];
    assign unused_wbits = ^bus_wdata;

    lwt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .strb     (strb)
    );

    lwt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .strb    (strb),
        .wbit    (bus_wdata[0]),
        .run_q   (run_q),
        .user_q  (user_q),
        .advance (advance)
    );

    lwt_counter #(.W(FIELD_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .wr_limit  (strb.wr_limit),
        .wr_alias  (strb.wr_alias),
        .rd_limit  (strb.rd_limit),
        .new_limit (wfield),
        .cnt_q     (cnt_q),
        .lim_q     (lim_q),
        .flag_q    (flag_q)
    );

    function automatic logic [WORD_W-1:0] pack_word(input logic f, input logic [FIELD_W-1:0] v);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[FIELD_LSB +: FIELD_W] = v;
        w[FLAG_BIT]            = f;
        return w;
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_LIMIT) || bus_addr == ADDR_W'(OFS_LIMIT_NR))
            bus_rdata = pack_word(flag_q, lim_q);
        else if (bus_addr == ADDR_W'(OFS_COUNT))
            bus_rdata = pack_word(flag_q, cnt_q);
        else if (bus_addr == ADDR_W'(OFS_RUN))
            bus_rdata = {31'b0, run_q};
        else if (bus_addr == ADDR_W'(OFS_CFG))
            bus_rdata = {31'b0, user_q};
    end

    assign irq = flag_q;

endmodule

// File: rtl/lwt_checker.sv
module lwt_checker #(
    parameter int W      = 21,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic [W-1:0]      cnt,
    input logic              user,
    input logic              run
);

    logic lim_wr;
    logic alias_wr;
    logic lim_rd;

    assign lim_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign alias_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
    assign lim_rd   = bus_sel && bus_rd && (bus_addr == ADDR_W'(0));

    a_r1_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    a_r5_limit_write_reload: assert property (@(posedge clk) disable iff (rst)
        lim_wr |=> (cnt == W'(1)) && !irq);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !lim_wr) |=> $stable(cnt));

    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (user && !run && !lim_wr) |=> $stable(cnt));

    a_r7_read_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (lim_rd && !tick) |=> !irq);

    a_r6_alias_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (alias_wr && !tick) |=> $stable(cnt) && $stable(irq));

endmodule

bind lwt_timer lwt_checker #(.W(FIELD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .irq      (irq),
    .cnt      (cnt_q),
    .user     (user_q),
    .run      (run_q)
);

// File: tb/sim_lwt_timer.sv
module sim_lwt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0;
    logic [31:0] rdata1;
    logic        irq0;
    logic        irq1;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lwt_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(sel[0]), .bus_wr(wr),
        .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0)
    );

    lwt_timer #(.FIELD_W(6), .FIELD_LSB(9)) u1 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(sel[1]), .bus_wr(wr),
        .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int u, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = (u == 0) ? 2'b01 : 2'b10;
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 2'b00; wr = 1'b0;
    endtask

    task automatic bus_read(input int u, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = (u == 0) ? 2'b01 : 2'b10;
        rd = 1'b1; addr = a;
        #1 d = (u == 0) ? rdata0 : rdata1;
        @(negedge clk);
        sel = 2'b00; rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic logic [31:0] cword(input logic f, input int v);
        return ({31'b0, f} << 31) | (32'(v) << 10);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(0, 3'd1, d); chk("R1 count after reset", d, 32'h0000_0400);
        bus_read(0, 3'd0, d); chk("R1 limit after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq0}, 32'h0);
        bus_read(0, 3'd3, d); chk("R1 run after reset", d, 32'h0);
        bus_read(0, 3'd4, d); chk("R1 cfg after reset", d, 32'h0);
        bus_read(1, 3'd1, d); chk("R9 u1 count after reset", d, 32'h0000_0200);

        // R4: count writes ignored, masked limit readback
        bus_write(0, 3'd1, 32'hFFFF_FFFF);
        bus_read(0, 3'd1, d); chk("R4 count write ignored", d, 32'h0000_0400);
        bus_write(0, 3'd0, 32'hFFFF_FFFF);
        bus_read(0, 3'd0, d); chk("R4 limit field mask", d, 32'h7FFF_FC00);

        // R2 / R5 / R7: sweep over small limits
        for (int lim = 2; lim <= 9; lim++) begin
            bus_write(0, 3'd0, 32'(lim) << 10);
            bus_read(0, 3'd1, d); chk("R5 limit write reloads", d, cword(1'b0, 1));
            chk("R5 limit write clears irq", {31'b0, irq0}, 32'h0);
            for (int k = 1; k <= 2 * (lim - 1); k++) begin
                logic fl;
                fl = (k >= lim - 1);
                ticks(1);
                bus_read(0, 3'd1, d);
                chk("R2 count sequence", d, cword(fl, (k % (lim - 1)) + 1));
                chk("R7 irq follows flag", {31'b0, irq0}, {31'b0, fl});
            end
            bus_read(0, 3'd0, d); chk("R7 limit word shows flag", d, cword(1'b1, lim));
            @(negedge clk);
            chk("R7 limit read clears irq", {31'b0, irq0}, 32'h0);
        end

        // R7: alias read leaves the flag
        bus_write(0, 3'd0, 32'd3 << 10);
        ticks(2);
        bus_read(0, 3'd2, d); chk("R7 alias read word", d, cword(1'b1, 3));
        @(negedge clk);
        chk("R7 alias read keeps irq", {31'b0, irq0}, 32'h1);
        bus_read(0, 3'd0, d);
        @(negedge clk);
        chk("R7 limit read drops irq", {31'b0, irq0}, 32'h0);

        // R6: non-resetting alias
        bus_write(0, 3'd0, 32'd10 << 10);
        ticks(4);
        bus_write(0, 3'd2, 32'd20 << 10);
        bus_read(0, 3'd1, d); chk("R6 alias keeps count", d, cword(1'b0, 5));
        bus_read(0, 3'd0, d); chk("R6 alias sets limit", d, cword(1'b0, 20));
        ticks(1);
        bus_write(0, 3'd2, 32'd4 << 10);
        ticks(1);
        bus_read(0, 3'd1, d); chk("R6 lowered limit wraps", d, cword(1'b1, 1));
        bus_write(0, 3'd2, 32'd30 << 10);
        bus_read(0, 3'd1, d); chk("R6 alias keeps flag", d, cword(1'b1, 1));
        chk("R6 alias keeps irq", {31'b0, irq0}, 32'h1);

        // R8: user mode gating by run bit
        bus_write(0, 3'd0, 32'd100 << 10);
        bus_write(0, 3'd4, 32'hFFFF_FFFF);
        bus_read(0, 3'd4, d); chk("R8 cfg reads bit0", d, 32'h1);
        ticks(3);
        bus_read(0, 3'd1, d); chk("R8 stopped holds", d, cword(1'b0, 1));
        bus_write(0, 3'd3, 32'hFFFF_FFFF);
        bus_read(0, 3'd3, d); chk("R8 run reads bit0", d, 32'h1);
        ticks(2);
        bus_read(0, 3'd1, d); chk("R8 running counts", d, cword(1'b0, 3));
        bus_write(0, 3'd3, 32'h0);
        ticks(2);
        bus_read(0, 3'd1, d); chk("R8 stopped again holds", d, cword(1'b0, 3));
        bus_write(0, 3'd4, 32'h0);
        ticks(1);
        bus_read(0, 3'd1, d); chk("R8 non-user ignores run", d, cword(1'b0, 4));

        // R3 / R9: full range on the small instance
        bus_write(1, 3'd0, 32'h0);
        ticks(62);
        bus_read(1, 3'd1, d); chk("R3 count at all-ones", d, 32'h0000_7E00);
        chk("R3 no irq before wrap", {31'b0, irq1}, 32'h0);
        ticks(1);
        bus_read(1, 3'd1, d); chk("R3 full range reload", d, 32'h8000_0200);
        chk("R9 u1 irq after wrap", {31'b0, irq1}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule